// File: doc/BRIEF.md
# Nibble-Bus Divider Programmer with Reference Divider

This block lets a host program the three divide values of a dual-modulus frequency synthesizer over a narrow bus. The bus has a 4-bit data field, a 3-bit address and a strobe. Each address selects one nibble-wide holding register. Together the eight registers hold three values:

- a 7-bit swallow count A,
- a 10-bit main count N,
- a 12-bit reference count R.

Where a value does not fill its top nibble, the unused data lines at that address are discarded. The assembled A, N and R values are driven continuously to the downstream counters.

The block also contains the reference divider. It runs on the system (oscillator) clock and emits one single-cycle pulse every R clocks. Any R from 3 to 4095 is honoured. Smaller values are raised to 3. A newly written R takes effect only when the divider next reloads, so the period in progress is never cut short.

The strobe and bus are sampled on the system clock. Every cycle in which the strobe is high writes the addressed nibble. While the strobe stays high, the register therefore follows the bus. When the strobe drops, the register keeps the last value written.

Top module: `nib_div_prog`

## Requirements
- R1: After reset, A, N and R all read zero and the reference pulse is low. The first pulse period is 3 clocks, because zero is raised to the minimum.
- R2: A strobe-high cycle at address 0 writes data bits 3..0 into A bits 3..0. Data bit 3 is the most significant bit of every nibble.
- R3: A strobe-high cycle at address 1 writes data bits 2..0 into A bits 6..4. Data bit 3 is ignored there.
- R4: Address 2 writes N bits 3..0 and address 3 writes N bits 7..4.
- R5: Address 4 writes data bits 1..0 into N bits 9..8. Data bits 3..2 are ignored there.
- R6: Addresses 5, 6 and 7 write R bits 3..0, 7..4 and 11..8 respectively.
- R7: While the strobe is low, no register changes, whatever the address and data lines do.
- R8: While the strobe is held high, the addressed register follows the bus every cycle. After the strobe falls it holds the last value written. Nibbles at other addresses are left untouched.
- R9: For R from 3 to 4095, the reference pulse is high for one cycle and recurs exactly every R clocks.
- R10: An R value of 0, 1 or 2 gives a pulse period of 3 clocks.
- R11: A change of R made part-way through a period does not alter that period. The new period starts at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System / oscillator clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| strobe_i | input | 1 | Write strobe, high writes the addressed nibble each cycle |
| addr_i | input | 3 | Nibble register select |
| data_i | input | 4 | Nibble data, bit 3 most significant |
| a_div_o | output | 7 | Assembled swallow count A |
| n_div_o | output | 10 | Assembled main count N |
| r_div_o | output | 12 | Assembled reference count R |
| fr_o | output | 1 | Reference pulse, one cycle every R clocks |

## Verification
The hardest case to reach is an R change that lands in the middle of a running reference period. The stimulus sets up a long period and lets it settle. Right after a pulse, it rewrites R to a much shorter value through the bus. It then measures the gap that ends at the next pulse, which must keep the old length, and the gap after that, which must take the new length. The clamp and the full 4095 range are reached in the same way, by writing R and timing several consecutive pulse gaps.

// File: rtl/nib_div_pkg.sv
package nib_div_pkg;
  localparam int unsigned NIB_W  = 4;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned N_REGS = 1 << ADDR_W;
  localparam int unsigned A_W    = 7;
  localparam int unsigned N_W    = 10;
  localparam int unsigned R_W    = 12;
  localparam int unsigned R_MIN  = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_A_LO  = 3'd0,
    SEL_A_HI  = 3'd1,
    SEL_N_LO  = 3'd2,
    SEL_N_MID = 3'd3,
    SEL_N_HI  = 3'd4,
    SEL_R_LO  = 3'd5,
    SEL_R_MID = 3'd6,
    SEL_R_HI  = 3'd7
  } nib_sel_e;

  // bits of each nibble that exist in the assembled value
  function automatic logic [NIB_W-1:0] nib_mask(input logic [ADDR_W-1:0] sel);
    case (nib_sel_e'(sel))
      SEL_A_HI: return 4'b0111;
      SEL_N_HI: return 4'b0011;
      default:  return 4'b1111;
    endcase
  endfunction
endpackage

// File: rtl/nib_latch_bank.sv
module nib_latch_bank
  import nib_div_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NIB_W-1:0]  data_i,
  output logic [A_W-1:0]    a_div_o,
  output logic [N_W-1:0]    n_div_o,
  output logic [R_W-1:0]    r_div_o
);
  logic [N_REGS-1:0][NIB_W-1:0] lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q <= '0;
    end else if (strobe_i) begin
      for (int i = 0; i < N_REGS; i++) begin
        if (addr_i == ADDR_W'(i)) lat_q[i] <= data_i & nib_mask(ADDR_W'(i));
      end
    end
  end

  assign a_div_o = {lat_q[SEL_A_HI][2:0], lat_q[SEL_A_LO]};
  assign n_div_o = {lat_q[SEL_N_HI][1:0], lat_q[SEL_N_MID], lat_q[SEL_N_LO]};
  assign r_div_o = {lat_q[SEL_R_HI], lat_q[SEL_R_MID], lat_q[SEL_R_LO]};

  // R7: idle strobe leaves every nibble untouched
  a_r7_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> $stable(lat_q));
  // R3: unused top bit of the A high nibble stays clear
  a_r3_a_hi_unused_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lat_q[SEL_A_HI][3] == 1'b0);
  // R5: unused top bits of the N high nibble stay clear
  a_r5_n_hi_unused_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lat_q[SEL_N_HI][3:2] == 2'b00);
  // R8: a write to the reference field leaves A and N alone
  a_r8_other_fields_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && addr_i >= 3'(SEL_R_LO)) |=> ($stable(a_div_o) && $stable(n_div_o)));
endmodule

// File: rtl/ref_divider.sv
module ref_divider
  import nib_div_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [R_W-1:0] r_div_i,
  output logic           fr_o
);
  logic [R_W-1:0] eff_r;
  logic [R_W-1:0] cnt_q;
  logic [R_W-1:0] period_q;
  logic           fr_q;
  logic           reload;

  assign eff_r  = (r_div_i < R_W'(R_MIN)) ? R_W'(R_MIN) : r_div_i;
  assign reload = (cnt_q <= R_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      period_q <= R_W'(R_MIN);
      fr_q     <= 1'b0;
    end else begin
      fr_q <= (cnt_q == R_W'(1));
      if (reload) begin
        cnt_q    <= eff_r;
        period_q <= eff_r;
      end else begin
        cnt_q <= cnt_q - R_W'(1);
      end
    end
  end

  assign fr_o = fr_q;

  // R10: the captured period never falls below the minimum
  a_r10_period_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_q >= R_W'(R_MIN));
  // R9: the pulse lasts exactly one cycle
  a_r9_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fr_o |=> !fr_o);
  // R11: the pulse coincides with a fresh reload of the counter
  a_r11_pulse_at_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fr_o |-> (cnt_q == period_q));
  // R11: the period is only captured at a reload
  a_r11_period_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q > R_W'(1)) |=> $stable(period_q));
endmodule

// File: rtl/nib_div_prog.sv
module nib_div_prog
  import nib_div_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NIB_W-1:0]  data_i,
  output logic [A_W-1:0]    a_div_o,
  output logic [N_W-1:0]    n_div_o,
  output logic [R_W-1:0]    r_div_o,
  output logic              fr_o
);
  logic [R_W-1:0] r_val;

  nib_latch_bank u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (strobe_i),
    .addr_i   (addr_i),
    .data_i   (data_i),
    .a_div_o  (a_div_o),
    .n_div_o  (n_div_o),
    .r_div_o  (r_val)
  );

  ref_divider u_rdiv (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .r_div_i (r_val),
    .fr_o    (fr_o)
  );

  assign r_div_o = r_val;
endmodule

// File: tb/nib_div_prog_tb.sv
module nib_div_prog_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strobe = 1'b0;
  logic [2:0] addr = '0;
  logic [3:0] data = '0;
  logic [6:0]  a_div;
  logic [9:0]  n_div;
  logic [11:0] r_div;
  logic        fr;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int last_t = 0;
  int last_gap = 0;
  int pulses = 0;

  always #4 clk = ~clk;

  nib_div_prog u_dut (
    .clk_i(clk), .rst_ni(rst_n), .strobe_i(strobe), .addr_i(addr),
    .data_i(data), .a_div_o(a_div), .n_div_o(n_div), .r_div_o(r_div), .fr_o(fr)
  );

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rst_n && fr) begin
      last_gap = cyc - last_t;
      last_t = cyc;
      pulses = pulses + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [3:0] d);
    @(negedge clk);
    addr = a; data = d; strobe = 1'b1;
    @(negedge clk);
    strobe = 1'b0;
  endtask

  task automatic wr_r(input int v);
    wr(3'd5, 4'(v));
    wr(3'd6, 4'(v >> 4));
    wr(3'd7, 4'(v >> 8));
  endtask

  task automatic next_gap(output int g);
    int p0;
    p0 = pulses;
    while (pulses == p0) @(negedge clk);
    g = last_gap;
  endtask

  task automatic t_reset();
    int g;
    check("R1 A", int'(a_div), 0);
    check("R1 N", int'(n_div), 0);
    check("R1 R", int'(r_div), 0);
    check("R1 fr", int'(fr), 0);
    next_gap(g);
    next_gap(g);
    check("R1 period", g, 3);
  endtask

  task automatic t_a_fields();
    wr(3'd0, 4'hA);
    check("R2 A lo", int'(a_div), 'hA);
    wr(3'd1, 4'hF);
    check("R3 A hi D3 ignored", int'(a_div), 'h7A);
    wr(3'd1, 4'h5);
    check("R3 A hi", int'(a_div), 'h5A);
  endtask

  task automatic t_n_fields();
    wr(3'd2, 4'h3);
    wr(3'd3, 4'hC);
    check("R4 N lo/mid", int'(n_div), 'hC3);
    wr(3'd4, 4'hE);
    check("R5 N hi D3..2 ignored", int'(n_div), 'h2C3);
    wr(3'd4, 4'hD);
    check("R5 N hi", int'(n_div), 'h1C3);
  endtask

  task automatic t_r_fields();
    wr(3'd5, 4'h9);
    wr(3'd6, 4'h6);
    wr(3'd7, 4'hB);
    check("R6 R", int'(r_div), 'hB69);
    check("R6 A untouched", int'(a_div), 'h5A);
  endtask

  task automatic t_idle();
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      addr = 3'(i); data = 4'(15 - i); strobe = 1'b0;
    end
    @(negedge clk);
    check("R7 A held", int'(a_div), 'h5A);
    check("R7 N held", int'(n_div), 'h1C3);
    check("R7 R held", int'(r_div), 'hB69);
  endtask

  task automatic t_follow();
    @(negedge clk);
    addr = 3'd0; strobe = 1'b1; data = 4'h1;
    @(negedge clk);
    check("R8 follow 1", int'(a_div), 'h51);
    data = 4'h8;
    @(negedge clk);
    check("R8 follow 2", int'(a_div), 'h58);
    data = 4'h6;
    @(negedge clk);
    strobe = 1'b0; data = 4'hF;
    @(negedge clk);
    @(negedge clk);
    check("R8 hold after fall", int'(a_div), 'h56);
    check("R8 N untouched", int'(n_div), 'h1C3);
  endtask

  task automatic t_period(input int v, input int exp, input string req);
    int g;
    wr_r(v);
    next_gap(g);
    next_gap(g);
    next_gap(g);
    check(req, g, exp);
    next_gap(g);
    check(req, g, exp);
  endtask

  task automatic t_midchange();
    int g;
    wr_r(100);
    next_gap(g);
    next_gap(g);
    next_gap(g);
    check("R11 settle 100", g, 100);
    repeat (10) @(negedge clk);
    wr_r(20);
    next_gap(g);
    check("R11 old period kept", g, 100);
    next_gap(g);
    check("R11 new period", g, 20);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    last_t = cyc;
    @(negedge clk);
    t_reset();
    t_a_fields();
    t_n_fields();
    t_r_fields();
    t_idle();
    t_follow();
    t_period(3, 3, "R9 R=3");
    t_period(10, 10, "R9 R=10");
    t_period(4095, 4095, "R9 R=4095");
    t_period(0, 3, "R10 R=0");
    t_period(1, 3, "R10 R=1");
    t_period(2, 3, "R10 R=2");
    t_midchange();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule